// File: doc/BRIEF.md
# Multi-Pixel Lane Word Packer

The block takes a group of pixels every input cycle and turns the groups into one continuous little-endian bit stream. It emits that stream as 64-bit words that are already split into four 16-bit lane slices. The pixel width is chosen with a bits-per-pixel input. That width also sets how many pixels a group carries and how they sit on the 128-bit input bus. A group can be 128 or 96 bits or any other product of count and width, while a word is always 64 bits. Leftover bits therefore stay in a residue store until a full word can be formed.

Both sides use valid/ready handshakes. The input side stalls when a further group would not fit into the residue store. The output side holds its word while the consumer is not ready. An end-of-line flag on an input group closes the line. The remaining bits go out in a final word padded with zeros, and that word carries a last flag. New groups wait until that final word has been taken.

Top module: `pixel_lane_packer`

## Requirements
- R1: The group layout follows the pixel width `in_bpp` (legal 1 to 32). For widths of 8 or less, 16 pixels sit in 8-bit slots. For widths 9 to 16, 8 pixels sit in 16-bit slots. For widths 17 to 32, 4 pixels sit in 32-bit slots. Pixel i is `in_data[i*slot +: in_bpp]`, and slot bits above the pixel width have no effect on the output.
- R2: Pixels are packed with no gaps into one bit stream. Pixel 0 of a group comes first, each pixel starts at its least significant bit, and stream bit 8k+b is bit b of stream byte k. Each group continues exactly where the previous one ended.
- R3: Stream byte k of a word (k = 0..7) goes to lane k mod 4. Bytes 0 to 3 sit in the low half of their lane slice and bytes 4 to 7 in the high half, so byte k lands at `out_data[16*(k%4) + 8*(k/4) +: 8]`.
- R4: `out_valid` is high exactly when at least 64 stream bits are buffered, or when a line end is pending and any bits remain.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R6: Without a pending line end, `in_ready` is high exactly when the buffered bit count plus the current group size is at most 192. The buffered count never exceeds 192.
- R7: A group accepted with `in_eol` set marks a line end. The final word of that line carries `out_last`, and its bits beyond the stream's end are zero. `in_ready` stays low from that acceptance until the last word is taken.
- R8: After reset the store is empty, `out_valid` is low and `in_ready` is high.
- R9: When a line ends exactly on a 64-bit boundary, no extra padding word is produced, and `out_last` sits on the final full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_bpp | input | 6 | Bits per pixel, 1 to 32; change only while idle |
| in_valid | input | 1 | Input group present |
| in_ready | output | 1 | Block can take the group this cycle |
| in_data | input | 128 | Pixel slots of the group |
| in_eol | input | 1 | Group is the last of a line |
| out_valid | output | 1 | Lane word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 64 | Four 16-bit lane slices, lane 0 lowest |
| out_last | output | 1 | Word closes the current line |

## Verification
If the internal fill count drifts by even one bit, every later stream byte shifts. The very next word on `out_data` then disagrees with the independently packed reference stream, and the `in_ready` pattern changes within the same cycle. Stale bits left above the fill level show up as nonzero padding in the last word of the next line. A line-end flag that fails to set or clear shows up as `out_last` on the wrong word or as `in_ready` stuck low. The bench uses random pixel data with garbage in the unused slot bits, random backpressure and random line ends across several widths. Directed lines of single groups hit both the padded and the exact-boundary endings.

// File: rtl/ppk_pkg.sv
package ppk_pkg;

  // Pixels carried by one input group for a given width (R1)
  function automatic int unsigned pix_per_group(input logic [5:0] bpp);
    if (bpp > 6'd16)      return 4;
    else if (bpp > 6'd8)  return 8;
    else                  return 16;
  endfunction

  // Slot pitch on the input bus for a given width (R1)
  function automatic int unsigned slot_width(input int unsigned in_w,
                                             input logic [5:0] bpp);
    return in_w / pix_per_group(bpp);
  endfunction

  // Stream bits contributed by one group (R2)
  function automatic int unsigned group_bits(input logic [5:0] bpp);
    return pix_per_group(bpp) * int'(bpp);
  endfunction

  // Output bit position of stream byte k in the lane word (R3)
  function automatic int unsigned lane_bit_pos(input int unsigned byte_idx,
                                               input int unsigned lanes,
                                               input int unsigned lane_w);
    return (byte_idx % lanes) * lane_w + (byte_idx / lanes) * 8;
  endfunction

endpackage

// File: rtl/ppk_compactor.sv
module ppk_compactor
  import ppk_pkg::*;
#(
  parameter int IN_W    = 128,
  parameter int BPP_W   = 6,
  parameter int MAX_PIX = 16
) (
  input  logic [IN_W-1:0]  slots,
  input  logic [BPP_W-1:0] bpp,
  output logic [IN_W-1:0]  packed_bits
);

  logic [IN_W-1:0] pix_mask;
  int unsigned     n_pix;
  int unsigned     slot_w;
  int unsigned     bpp_i;
  logic [IN_W-1:0] terms [MAX_PIX];

  always_comb begin
    n_pix    = pix_per_group(bpp);
    slot_w   = slot_width(IN_W, bpp);
    bpp_i    = int'(bpp);
    pix_mask = (IN_W'(1) << bpp) - IN_W'(1);
  end

  // One term per slot: isolate the pixel, then move it to its stream offset
  for (genvar i = 0; i < MAX_PIX; i++) begin : g_slot
    assign terms[i] = (i < int'(n_pix))
                    ? (((slots >> (i * slot_w)) & pix_mask) << (i * bpp_i))
                    : '0;
  end

  always_comb begin
    packed_bits = '0;
    for (int i = 0; i < MAX_PIX; i++) packed_bits = packed_bits | terms[i];
  end

endmodule

// File: rtl/ppk_residue.sv
module ppk_residue #(
  parameter int IN_W  = 128,
  parameter int OUT_W = 64,
  parameter int BUF_W = 192,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grp_accept,
  input  logic [IN_W-1:0]  grp_bits,
  input  logic [CNT_W-1:0] grp_len,
  input  logic             grp_eol,
  input  logic             word_emit,
  output logic [OUT_W-1:0] stream_word,
  output logic [CNT_W-1:0] fill,
  output logic             pend,
  output logic             word_avail,
  output logic             word_last,
  output logic             room_ok
);

  logic [BUF_W-1:0] store_q, store_n;
  logic [CNT_W-1:0] fill_q, fill_n;
  logic             pend_q, pend_n;
  logic [CNT_W:0]   room_sum;

  assign stream_word = store_q[OUT_W-1:0];
  assign fill        = fill_q;
  assign pend        = pend_q;

  always_comb begin
    word_avail = (fill_q >= CNT_W'(OUT_W)) || (pend_q && (fill_q != '0));
    word_last  = pend_q && (fill_q <= CNT_W'(OUT_W));
    room_sum   = {1'b0, fill_q} + {1'b0, grp_len};
    room_ok    = !pend_q && (room_sum <= (CNT_W+1)'(BUF_W));
  end

  always_comb begin
    store_n = store_q;
    fill_n  = fill_q;
    pend_n  = pend_q;
    if (word_emit) begin
      if (word_last) begin
        store_n = '0;
        fill_n  = '0;
        pend_n  = 1'b0;
      end else begin
        store_n = store_q >> OUT_W;
        fill_n  = fill_q - CNT_W'(OUT_W);
      end
    end
    if (grp_accept) begin
      store_n = store_n | (BUF_W'(grp_bits) << fill_n);
      fill_n  = fill_n + grp_len;
      if (grp_eol) pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      fill_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      store_q <= store_n;
      fill_q  <= fill_n;
      pend_q  <= pend_n;
    end
  end

endmodule

// File: rtl/ppk_lane_map.sv
module ppk_lane_map
  import ppk_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16
) (
  input  logic [LANES*LANE_W-1:0] stream_word,
  output logic [LANES*LANE_W-1:0] lane_word
);

  localparam int N_BYTES = LANES * LANE_W / 8;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    localparam int POS = lane_bit_pos(k, LANES, LANE_W);
    assign lane_word[POS +: 8] = stream_word[8*k +: 8];
  end

endmodule

// File: rtl/pixel_lane_packer.sv
module pixel_lane_packer
  import ppk_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 16,
  parameter int IN_W   = 128,
  parameter int BPP_W  = 6,
  parameter int BUF_W  = 192
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BPP_W-1:0]        in_bpp,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [IN_W-1:0]         in_data,
  input  logic                    in_eol,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] out_data,
  output logic                    out_last
);

  localparam int OUT_W   = LANES * LANE_W;
  localparam int CNT_W   = $clog2(BUF_W + 1);
  localparam int MAX_PIX = 16;

  logic [IN_W-1:0]  grp_packed;
  logic [CNT_W-1:0] grp_bits;
  logic [CNT_W-1:0] fill_level;
  logic [OUT_W-1:0] stream_word;
  logic             eol_pending;
  logic             word_avail, word_last, room_ok;
  logic             grp_accept, word_emit;

  assign grp_bits   = CNT_W'(group_bits(in_bpp));
  assign grp_accept = in_valid && room_ok;
  assign word_emit  = word_avail && out_ready;
  assign in_ready   = room_ok;
  assign out_valid  = word_avail;
  assign out_last   = word_last;

  ppk_compactor #(.IN_W(IN_W), .BPP_W(BPP_W), .MAX_PIX(MAX_PIX)) u_compact (
    .slots       (in_data),
    .bpp         (in_bpp),
    .packed_bits (grp_packed)
  );

  ppk_residue #(.IN_W(IN_W), .OUT_W(OUT_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_residue (
    .clk         (clk),
    .rst_n       (rst_n),
    .grp_accept  (grp_accept),
    .grp_bits    (grp_packed),
    .grp_len     (grp_bits),
    .grp_eol     (in_eol),
    .word_emit   (word_emit),
    .stream_word (stream_word),
    .fill        (fill_level),
    .pend        (eol_pending),
    .word_avail  (word_avail),
    .word_last   (word_last),
    .room_ok     (room_ok)
  );

  ppk_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .stream_word (stream_word),
    .lane_word   (out_data)
  );

endmodule

// File: rtl/ppk_checker.sv
module ppk_checker #(
  parameter int OUT_W = 64,
  parameter int BUF_W = 192,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_eol,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_last,
  input logic [CNT_W-1:0] fill_level,
  input logic             eol_pending
);

  // R4: a full word always shows as valid
  a_r4_full_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level >= CNT_W'(OUT_W)) |-> out_valid);

  // R4: no valid without a full word or a pending line end
  a_r4_no_early_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((fill_level >= CNT_W'(OUT_W)) || eol_pending));

  // R5: a stalled word is held
  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R6: store never overflows
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= CNT_W'(BUF_W));

  // R7: input closed right after a line-end group is taken
  a_r7_block_after_eol: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_eol) |=> !in_ready);

  // R7: last flag only on a presented word
  a_r7_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9: taking the last word empties the store and clears the line end
  a_r9_last_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> ((fill_level == '0) && !eol_pending));

endmodule

bind pixel_lane_packer ppk_checker #(
  .OUT_W (LANES * LANE_W),
  .BUF_W (BUF_W),
  .CNT_W ($clog2(BUF_W + 1))
) u_ppk_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_eol      (in_eol),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_last    (out_last),
  .fill_level  (fill_level),
  .eol_pending (eol_pending)
);

// File: tb/pixel_lane_packer_bench.sv
`timescale 1ns/1ps
module pixel_lane_packer_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [5:0]   in_bpp = 6'd10;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         in_eol = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [63:0]  out_data;
  logic         out_last;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit bq[$];
  bit mpend = 1'b0;
  bit prev_hold = 1'b0;
  logic [63:0] prev_data = '0;
  bit prev_last = 1'b0;

  always #10 clk = ~clk;

  pixel_lane_packer u_pixel_lane_packer (
    .clk(clk), .rst_n(rst_n), .in_bpp(in_bpp), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int count_pix(input int bpp);
    if (bpp <= 8)  return 16;
    if (bpp <= 16) return 8;
    return 4;
  endfunction

  // R1 R2: append one group to the reference stream
  function automatic void push_group(input logic [127:0] d, input int bpp);
    int np = count_pix(bpp);
    int pitch = 128 / np;
    for (int i = 0; i < np; i++)
      for (int b = 0; b < bpp; b++)
        bq.push_back(d[i*pitch + b]);
  endfunction

  // R3: build the expected lane word from the head of the stream
  function automatic logic [63:0] expect_word();
    logic [63:0] w = '0;
    for (int k = 0; k < 8; k++)
      for (int b = 0; b < 8; b++) begin
        int idx = 8*k + b;
        int pos = (k & 3) * 16 + (k >> 2) * 8 + b;
        w[pos] = (idx < bq.size()) ? bq[idx] : 1'b0;
      end
    return w;
  endfunction

  task automatic cycle(input bit v, input bit e, input bit r, output bit taken);
    int  sz;
    bit  exp_v, exp_r, exp_l;
    logic [63:0] ew;
    @(negedge clk);
    in_valid  = v;
    in_eol    = e;
    out_ready = r;
    in_data   = {$urandom(), $urandom(), $urandom(), $urandom()};
    #2;
    sz    = bq.size();
    exp_v = (sz >= 64) || (mpend && sz > 0);
    exp_r = !mpend && (sz + count_pix(int'(in_bpp)) * int'(in_bpp) <= 192);
    check(out_valid == exp_v, "R4", "out_valid", 64'(out_valid), 64'(exp_v));
    check(in_ready == exp_r, mpend ? "R7" : "R6", "in_ready", 64'(in_ready), 64'(exp_r));
    if (prev_hold)
      check(out_valid && out_data == prev_data && out_last == prev_last, "R5",
            "held word", out_data, prev_data);
    exp_l = mpend && sz <= 64;
    if (exp_v && out_valid) begin
      ew = expect_word();
      check(out_data == ew, "R1 R2 R3", "out_data", out_data, ew);
      check(out_last == exp_l, (mpend && sz == 64) ? "R9" : "R7", "out_last",
            64'(out_last), 64'(exp_l));
    end
    prev_hold = out_valid && !out_ready;
    prev_data = out_data;
    prev_last = out_last;
    if (exp_v && out_valid && out_ready) begin
      if (exp_l) begin
        bq.delete();
        mpend = 1'b0;
      end else begin
        for (int i = 0; i < 64; i++) void'(bq.pop_front());
      end
    end
    taken = v && in_ready && exp_r;
    if (taken) begin
      push_group(in_data, int'(in_bpp));
      if (e) mpend = 1'b1;
    end
  endtask

  task automatic run_phase(input int bpp, input int n, input int eol_pct, input int rdy_pct);
    bit t;
    int guard;
    @(negedge clk);
    in_bpp = 6'(bpp);
    for (int c = 0; c < n; c++)
      cycle(($urandom() % 100) < 80, ($urandom() % 100) < eol_pct,
            ($urandom() % 100) < rdy_pct, t);
    t = 1'b0;
    guard = 0;
    while (!t && guard < 100) begin
      cycle(1'b1, 1'b1, ($urandom() % 100) < rdy_pct, t);
      guard++;
    end
    guard = 0;
    while ((bq.size() != 0 || mpend) && guard < 100) begin
      cycle(1'b0, 1'b0, 1'b1, t);
      guard++;
    end
    check(bq.size() == 0 && !mpend, "R7", "line drained", 64'(bq.size()), 64'd0);
  endtask

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0, "R8", "out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", 64'(in_ready), 64'd1);
    // directed: one-group lines, 80 bits padded (R7) and 128 bits exact (R9)
    run_phase(10, 40, 100, 90);
    run_phase(16, 40, 100, 70);
    run_phase(8, 40, 100, 100);
    run_phase(24, 40, 100, 60);
    // random mixes of widths, line ends and backpressure
    run_phase(10, 1500, 5, 70);
    run_phase(24, 1500, 4, 85);
    run_phase(6, 1200, 6, 60);
    run_phase(12, 1200, 3, 50);
    run_phase(16, 1200, 8, 90);
    run_phase(7, 1000, 10, 40);
    run_phase(32, 1000, 5, 75);
    run_phase(1, 800, 10, 80);
    run_phase(20, 1000, 2, 100);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule